// File: doc/BRIEF.md
# Per-Thread Address Wait Monitor

This block keeps one address monitor for each hardware thread. It gives a core the two halves of a wait-on-memory idiom. A thread first arms its monitor with an address. It then issues a wait request with the physical address of the line it cares about. The block answers whether the thread may go to sleep. A snoop port carries the physical addresses of observed writes and invalidations. Every thread whose monitored line is hit by a snoop gets a one-cycle wake pulse.

A wakeup that arrives early is never lost. If a snoop hits the line of a thread's armed address while the thread is not yet waiting, a pending flag is set. The next wait request from that thread is refused, which consumes the flag. The line size is a power-of-two parameter. Each comparison works on line addresses, meaning the address with its byte-offset bits cleared.

Responses, wake pulses and the error flag are all registered. They appear on the clock edge after the request or snoop that causes them.

Top module: `addr_wait_monitor`

## Requirements
- R1: After reset every monitor is unarmed, not waiting and has no pending wakeup. `wake`, `wait_resp_valid` and `req_err` are all 0.
- R2: An arm request for a thread sets its armed flag, records the given address and clears the stored line address to zero. Re-arming replaces both the recorded address and the stored line.
- R3: A wait request to a thread with no pending wakeup does three things: it stores the physical address with its low log2(LINE_BYTES) bits forced to 0, sets the waiting flag, and answers `wait_resp_valid`=1 with `wait_resp_sleep`=1 one cycle later.
- R4: A wait request to a thread whose wakeup-pending flag is set clears that flag and answers `wait_resp_sleep`=0. The waiting flag is left unchanged. A second wait after that answers sleep again.
- R5: A snoop wakes a thread only when the thread is armed and waiting and the snoop's line equals the stored line. On a match the waiting flag is cleared and bit tid of `wake` is 1 for exactly one cycle, one cycle after the snoop.
- R6: A snoop to a different line, or to a thread that is not both armed and waiting, gives no wake and leaves that thread's monitor as it was.
- R7: The snoop address is reduced to its line before the comparison, so any byte offset within the monitored line matches.
- R8: A snoop whose line equals the line of an armed, non-waiting thread's recorded address sets that thread's wakeup-pending flag and produces no wake pulse.
- R9: One snoop is compared against all threads at once, and any number of `wake` bits can be 1 in the same cycle.
- R10: A request whose thread ID is THREADS or larger changes no monitor and gives no wait response. It raises `req_err` for one cycle, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid | input | 1 | Arm request strobe |
| arm_tid | input | TID_W | Thread to arm |
| arm_addr | input | ADDR_W | Address recorded by the arm |
| wait_valid | input | 1 | Wait request strobe |
| wait_tid | input | TID_W | Thread asking to wait |
| wait_paddr | input | ADDR_W | Physical address of the line to wait on |
| wait_resp_valid | output | 1 | Wait answer present (one cycle after request) |
| wait_resp_sleep | output | 1 | 1: thread may sleep, 0: wakeup was already pending |
| snoop_valid | input | 1 | Observed write or invalidation strobe |
| snoop_addr | input | ADDR_W | Physical address of the observed access |
| wake | output | THREADS | One-cycle wake pulse per thread |
| req_err | output | 1 | Out-of-range thread ID seen on arm or wait |

## Verification
Some properties are checked by assertions on every cycle. A refusal must clear the pending flag, and a non-refused wait must leave the thread waiting on a line-aligned address. A wake must drop the waiting flag. No wake bit may rise without a snoop in the cycle before. An out-of-range wait must never produce a response.

Other behaviours can only be shown by the bench's scenarios, because they depend on what was stored earlier. These are: the early wakeup being consumed by exactly one refused wait, a re-arm discarding the old line, byte offsets matching within the line, and several threads waking together.

// File: rtl/awm_pkg.sv
package awm_pkg;

  typedef enum logic {
    RESP_GO    = 1'b0,
    RESP_SLEEP = 1'b1
  } wait_resp_e;

  function automatic int unsigned offset_bits(input int unsigned line_bytes);
    return $clog2(line_bytes);
  endfunction

endpackage

// File: rtl/awm_req_decode.sv
module awm_req_decode #(
  parameter int THREADS = 5,
  parameter int TID_W   = 3
) (
  input  logic               req_valid,
  input  logic [TID_W-1:0]   req_tid,
  output logic [THREADS-1:0] req_hit,
  output logic               req_bad
);
  localparam logic [TID_W:0] TID_LIMIT = (TID_W+1)'(THREADS);

  for (genvar t = 0; t < THREADS; t++) begin : g_hit
    assign req_hit[t] = req_valid && (req_tid == TID_W'(t));
  end

  assign req_bad = req_valid && ({1'b0, req_tid} >= TID_LIMIT);

  always_comb begin
    if (req_bad) begin
      AST_BAD_HITS_NONE: assert (req_hit == '0); // R10
    end
  end
endmodule

// File: rtl/awm_slot.sv
module awm_slot #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_hit,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              wait_hit,
  input  logic [ADDR_W-1:0] wait_paddr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              wake_ev,
  output logic              refuse_ev
);
  import awm_pkg::*;

  localparam int unsigned OFS_B = offset_bits(LINE_BYTES);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(LINE_BYTES - 1);

  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a & ~OFS_MASK;
  endfunction

  logic              armed_q, waiting_q, pending_q;
  logic [ADDR_W-1:0] addr_q, line_q;

  logic [ADDR_W-1:0] snoop_line;
  logic              hit_waiting, hit_early, pend_set;

  assign snoop_line  = line_of(snoop_addr);
  assign hit_waiting = armed_q && waiting_q && (snoop_line == line_q);
  assign hit_early   = armed_q && !waiting_q && (snoop_line == line_of(addr_q));
  assign wake_ev     = snoop_valid && hit_waiting;
  assign pend_set    = snoop_valid && hit_early;
  assign refuse_ev   = wait_hit && pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      waiting_q <= 1'b0;
      pending_q <= 1'b0;
      addr_q    <= '0;
      line_q    <= '0;
    end else begin
      if (arm_hit) begin
        armed_q <= 1'b1;
        addr_q  <= arm_addr;
        line_q  <= '0;
      end
      if (wake_ev) waiting_q <= 1'b0;
      if (wait_hit) begin
        if (pending_q) begin
          pending_q <= 1'b0;
        end else begin
          line_q    <= line_of(wait_paddr);
          waiting_q <= 1'b1;
        end
      end
      if (pend_set) pending_q <= 1'b1;
    end
  end

  AST_ARM_ZERO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    arm_hit && !wait_hit |=> armed_q && (line_q == '0)); // R2
  AST_WAIT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    wait_hit && !pending_q |=> waiting_q && ((line_q & OFS_MASK) == '0)); // R3
  AST_REFUSE_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_ev && !pend_set |=> !pending_q); // R4
  AST_REFUSE_KEEPS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_ev && !wake_ev |=> waiting_q == $past(waiting_q)); // R4
  AST_WAKE_DROPS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ev && !wait_hit |=> !waiting_q); // R5
  AST_EARLY_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set |=> pending_q); // R8
endmodule

// File: rtl/addr_wait_monitor.sv
module addr_wait_monitor #(
  parameter int THREADS    = 5,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_valid,
  input  logic [TID_W-1:0]   arm_tid,
  input  logic [ADDR_W-1:0]  arm_addr,
  input  logic               wait_valid,
  input  logic [TID_W-1:0]   wait_tid,
  input  logic [ADDR_W-1:0]  wait_paddr,
  output logic               wait_resp_valid,
  output logic               wait_resp_sleep,
  input  logic               snoop_valid,
  input  logic [ADDR_W-1:0]  snoop_addr,
  output logic [THREADS-1:0] wake,
  output logic               req_err
);
  import awm_pkg::*;

  logic [THREADS-1:0] arm_hit, wait_hit, wake_vec, refuse_vec;
  logic               arm_bad, wait_bad;
  wait_resp_e         resp_kind;

  awm_req_decode #(.THREADS(THREADS), .TID_W(TID_W)) u_arm_dec (
    .req_valid(arm_valid), .req_tid(arm_tid), .req_hit(arm_hit), .req_bad(arm_bad));

  awm_req_decode #(.THREADS(THREADS), .TID_W(TID_W)) u_wait_dec (
    .req_valid(wait_valid), .req_tid(wait_tid), .req_hit(wait_hit), .req_bad(wait_bad));

  for (genvar t = 0; t < THREADS; t++) begin : g_slot
    awm_slot #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_hit    (arm_hit[t]),
      .arm_addr   (arm_addr),
      .wait_hit   (wait_hit[t]),
      .wait_paddr (wait_paddr),
      .snoop_valid(snoop_valid),
      .snoop_addr (snoop_addr),
      .wake_ev    (wake_vec[t]),
      .refuse_ev  (refuse_vec[t])
    );
  end

  assign resp_kind = (|refuse_vec) ? RESP_GO : RESP_SLEEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_resp_valid <= 1'b0;
      wait_resp_sleep <= 1'b0;
      wake            <= '0;
      req_err         <= 1'b0;
    end else begin
      wait_resp_valid <= |wait_hit;
      wait_resp_sleep <= (|wait_hit) && (resp_kind == RESP_SLEEP);
      wake            <= wake_vec;
      req_err         <= arm_bad || wait_bad;
    end
  end

  AST_WAKE_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake) |-> $past(snoop_valid)); // R5
  AST_BAD_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wait_bad |=> !wait_resp_valid && req_err); // R10
  AST_SLEEP_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wait_resp_sleep |-> wait_resp_valid); // R3
endmodule

// File: tb/addr_wait_monitor_test.sv
module addr_wait_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT  = 5;
  localparam int AW  = 32;
  localparam int LB  = 64;
  localparam int TW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm_valid = 1'b0, wait_valid = 1'b0, snoop_valid = 1'b0;
  logic [TW-1:0] arm_tid = '0, wait_tid = '0;
  logic [AW-1:0] arm_addr = '0, wait_paddr = '0, snoop_addr = '0;
  logic          wait_resp_valid, wait_resp_sleep, req_err;
  logic [NT-1:0] wake;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_wait_monitor #(.THREADS(NT), .ADDR_W(AW), .LINE_BYTES(LB)) uut (
    .clk(clk), .rst_n(rst_n),
    .arm_valid(arm_valid), .arm_tid(arm_tid), .arm_addr(arm_addr),
    .wait_valid(wait_valid), .wait_tid(wait_tid), .wait_paddr(wait_paddr),
    .wait_resp_valid(wait_resp_valid), .wait_resp_sleep(wait_resp_sleep),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .wake(wake), .req_err(req_err));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // each op: drive after a falling edge, outputs valid at the next falling edge
  task automatic do_arm(input int tid, input logic [AW-1:0] a);
    arm_valid = 1'b1; arm_tid = TW'(tid); arm_addr = a;
    @(negedge clk);
    arm_valid = 1'b0;
  endtask

  task automatic do_wait(input int tid, input logic [AW-1:0] a);
    wait_valid = 1'b1; wait_tid = TW'(tid); wait_paddr = a;
    @(negedge clk);
    wait_valid = 1'b0;
  endtask

  task automatic do_snoop(input logic [AW-1:0] a);
    snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 wake", 32'(wake), 0);
    chk("R1 resp_valid", 32'(wait_resp_valid), 0);
    chk("R1 err", 32'(req_err), 0);
  endtask

  task automatic t_basic_and_early();
    do_arm(0, 32'h1000);
    chk("R10 in-range arm no err", 32'(req_err), 0);
    do_wait(0, 32'h1023);
    chk("R3 resp valid", 32'(wait_resp_valid), 1);
    chk("R3 sleep", 32'(wait_resp_sleep), 1);
    do_snoop(32'h103F);
    chk("R5 R7 wake t0 other byte", 32'(wake), 32'h1);
    idle();
    chk("R5 wake is one pulse", 32'(wake), 0);
    do_snoop(32'h1004);
    chk("R8 early hit no wake", 32'(wake), 0);
    do_wait(0, 32'h1000);
    chk("R4 refused wait", 32'(wait_resp_sleep), 0);
    chk("R4 refused still valid", 32'(wait_resp_valid), 1);
    do_wait(0, 32'h1000);
    chk("R4 pending consumed, sleep", 32'(wait_resp_sleep), 1);
    do_snoop(32'h1000);
    chk("R5 wake after re-wait", 32'(wake), 32'h1);
  endtask

  task automatic t_mismatch();
    do_arm(1, 32'h2000);
    do_wait(1, 32'h2000);
    do_snoop(32'h2040);
    chk("R6 neighbour line no wake", 32'(wake), 0);
    do_snoop(32'h2008);
    chk("R6 state kept, wake t1", 32'(wake), 32'h2);
    do_wait(2, 32'h3000);
    chk("R3 unarmed wait sleeps", 32'(wait_resp_sleep), 1);
    do_snoop(32'h3000);
    chk("R6 unarmed no wake", 32'(wake), 0);
  endtask

  task automatic t_rearm();
    do_arm(3, 32'h0);
    do_wait(3, 32'h5000);
    do_snoop(32'h5000);
    chk("R5 t3 wake", 32'(wake), 32'h8);
    do_arm(3, 32'h7000);
    do_snoop(32'h5000);
    chk("R2 old line gone", 32'(wake), 0);
    do_wait(3, 32'h6000);
    chk("R2 no pending from old line", 32'(wait_resp_sleep), 1);
    do_snoop(32'h6030);
    chk("R2 new wait line wakes", 32'(wake), 32'h8);
  endtask

  task automatic t_parallel();
    do_arm(0, 32'h9000);
    do_arm(1, 32'h9000);
    do_arm(4, 32'h9000);
    do_wait(0, 32'h9001);
    do_wait(1, 32'h9022);
    do_wait(4, 32'h903F);
    do_snoop(32'h9010);
    chk("R9 three threads wake", 32'(wake), 32'h13);
  endtask

  task automatic t_range();
    do_arm(5, 32'hA000);
    chk("R10 arm tid 5 err", 32'(req_err), 1);
    do_wait(7, 32'hA000);
    chk("R10 wait tid 7 err", 32'(req_err), 1);
    chk("R10 wait tid 7 no resp", 32'(wait_resp_valid), 0);
    idle();
    chk("R10 err one pulse", 32'(req_err), 0);
    do_snoop(32'hA000);
    chk("R10 bad arm left no monitor", 32'(wake), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_and_early();
    t_mismatch();
    t_rearm();
    t_parallel();
    t_range();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule